// File: doc/BRIEF.md
# Spectral Matcher Control and Status Register Bank

This block is the software-facing register bank of a spectral signature matching engine. Through a word-wide register port it holds the run configuration: the band count per spectrum, the number of reference signatures in the library, and the base addresses of the captured spectrum and of the reference library. These values drive the engine directly.

A combined control/status word launches and aborts runs. Writing its action bits produces one-cycle `eng_start` and `eng_abort` pulses toward the engine. Its read-only part shows the engine's live idle and ready lines and three sticky outcome flags: done, error and cancelled. When a run finishes, the identifier and error value of the closest and the most distant reference signature are captured into four read-only result words. A synchronous clear input returns every register to zero and overrides any other action in the same cycle.

Register map (word offsets on `reg_addr`):
- 0: control/status. Write bit0 = launch, bit1 = abort. Read bit2 = idle, bit3 = ready, bit4 = done, bit5 = error, bit6 = cancelled. Bits 0 and 1 read as zero.
- 1: band count. 2: signature count.
- 3: spectrum base. 4: library base.
- 5: best id. 6: best error. 7: worst id. 8: worst error.

Top module: `spx_ctrl_regs`

## Requirements
- R1: Writes to offsets 1 to 4 store the configuration and drive `cfg_bands`, `cfg_sigs`, `cfg_spec_base` and `cfg_lib_base` from the following cycle. Reads return the stored value with bits above the field width as zero (band count 7 bits, signature count 6 bits).
- R2: A read of any offset from 9 to 15 returns zero. Bits 0, 1 and 7 to 31 of the status word read as zero.
- R3: Writing 1 to bit0 of offset 0 while `eng_idle` is high and both counts are nonzero raises `eng_start` for exactly one cycle, in the cycle after the write. When `eng_idle` is low the write has no effect.
- R4: An accepted launch clears the done, error and cancelled flags.
- R5: A launch written while idle with a band count or signature count of zero sets error, clears done and cancelled, and gives no `eng_start`.
- R6: Writing 1 to bit1 of offset 0 while `eng_idle` is low and `eng_done` is low raises `eng_abort` for one cycle and sets cancelled. When `eng_idle` is high the write has no effect.
- R7: `eng_done` with `eng_error` low sets done and clears error. With `eng_error` high it sets error and clears done. Done and error are never set together.
- R8: The four result registers capture `res_*` only on `eng_done` with `eng_error` low. At all other times they hold their value.
- R9: When an abort write and `eng_done` fall in the same cycle, the completion is taken: no abort pulse, cancelled unchanged, done and results updated.
- R10: `clear` high zeroes all registers and both pulses on the next edge, even if a write arrives in the same cycle. `rst_n` low does the same asynchronously.
- R11: The status word shows `eng_idle` on bit 2 and `eng_ready` on bit 3 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear, highest priority |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| eng_idle | input | 1 | Engine is idle |
| eng_ready | input | 1 | Engine accepts data |
| eng_done | input | 1 | Engine finished a run (pulse) |
| eng_error | input | 1 | Qualifies `eng_done` as a failed run |
| res_best_id | input | 6 | Closest signature identifier |
| res_best_err | input | 32 | Closest signature error |
| res_worst_id | input | 6 | Most distant signature identifier |
| res_worst_err | input | 32 | Most distant signature error |
| eng_start | output | 1 | One-cycle launch pulse |
| eng_abort | output | 1 | One-cycle abort pulse |
| cfg_bands | output | 7 | Band count |
| cfg_sigs | output | 6 | Signature count |
| cfg_spec_base | output | 32 | Captured spectrum base address |
| cfg_lib_base | output | 32 | Reference library base address |

## Verification
Two kinds of action can meet in one cycle. An abort write can arrive in the cycle where the engine reports completion. A clear can arrive together with an accepted launch write. The bench makes both happen by driving the write and the competing input on the same edge. It then judges the outcome against its model: completion takes precedence over the abort (no pulse, no cancelled flag, results captured), and clear takes precedence over everything (no launch pulse, all registers zero). Every other cycle of the run is also compared against the model.

// File: rtl/spx_ctrl_regs.sv
module spx_ctrl_regs #(
  parameter int DATA_W  = 32,
  parameter int BANDS_W = 7,
  parameter int SIGS_W  = 6,
  parameter int PTR_W   = 32,
  parameter int ERR_W   = 32,
  parameter int OFS_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              reg_wr,
  input  logic [OFS_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              eng_idle,
  input  logic              eng_ready,
  input  logic              eng_done,
  input  logic              eng_error,
  input  logic [SIGS_W-1:0] res_best_id,
  input  logic [ERR_W-1:0]  res_best_err,
  input  logic [SIGS_W-1:0] res_worst_id,
  input  logic [ERR_W-1:0]  res_worst_err,
  output logic              eng_start,
  output logic              eng_abort,
  output logic [BANDS_W-1:0] cfg_bands,
  output logic [SIGS_W-1:0] cfg_sigs,
  output logic [PTR_W-1:0]  cfg_spec_base,
  output logic [PTR_W-1:0]  cfg_lib_base
);

  localparam logic [OFS_W-1:0] A_CTRL = OFS_W'(0);
  localparam logic [OFS_W-1:0] A_BAND = OFS_W'(1);
  localparam logic [OFS_W-1:0] A_SIGS = OFS_W'(2);
  localparam logic [OFS_W-1:0] A_SPEC = OFS_W'(3);
  localparam logic [OFS_W-1:0] A_LIB  = OFS_W'(4);
  localparam logic [OFS_W-1:0] A_BID  = OFS_W'(5);
  localparam logic [OFS_W-1:0] A_BERR = OFS_W'(6);
  localparam logic [OFS_W-1:0] A_WID  = OFS_W'(7);
  localparam logic [OFS_W-1:0] A_WERR = OFS_W'(8);

  logic done_q, err_q, canc_q;
  logic [SIGS_W-1:0] best_id_q, worst_id_q;
  logic [ERR_W-1:0]  best_err_q, worst_err_q;

  wire ctrl_wr  = reg_wr && (reg_addr == A_CTRL);
  wire cfg_ok   = (cfg_bands != '0) && (cfg_sigs != '0);
  wire go_req   = ctrl_wr && reg_wdata[0] && eng_idle;
  wire stop_req = ctrl_wr && reg_wdata[1] && !eng_idle && !eng_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eng_start <= 1'b0; eng_abort <= 1'b0;
      cfg_bands <= '0; cfg_sigs <= '0; cfg_spec_base <= '0; cfg_lib_base <= '0;
      done_q <= 1'b0; err_q <= 1'b0; canc_q <= 1'b0;
      best_id_q <= '0; best_err_q <= '0; worst_id_q <= '0; worst_err_q <= '0;
    end else if (clear) begin
      eng_start <= 1'b0; eng_abort <= 1'b0;
      cfg_bands <= '0; cfg_sigs <= '0; cfg_spec_base <= '0; cfg_lib_base <= '0;
      done_q <= 1'b0; err_q <= 1'b0; canc_q <= 1'b0;
      best_id_q <= '0; best_err_q <= '0; worst_id_q <= '0; worst_err_q <= '0;
    end else begin
      eng_start <= go_req && cfg_ok;
      eng_abort <= stop_req;
      if (reg_wr) begin
        case (reg_addr)
          A_BAND:  cfg_bands     <= reg_wdata[BANDS_W-1:0];
          A_SIGS:  cfg_sigs      <= reg_wdata[SIGS_W-1:0];
          A_SPEC:  cfg_spec_base <= reg_wdata[PTR_W-1:0];
          A_LIB:   cfg_lib_base  <= reg_wdata[PTR_W-1:0];
          default: ;
        endcase
      end
      if (eng_done) begin
        done_q <= !eng_error;
        err_q  <= eng_error;
        if (!eng_error) begin
          best_id_q  <= res_best_id;  best_err_q  <= res_best_err;
          worst_id_q <= res_worst_id; worst_err_q <= res_worst_err;
        end
      end
      if (stop_req) canc_q <= 1'b1;
      if (go_req) begin
        done_q <= 1'b0;
        canc_q <= 1'b0;
        err_q  <= !cfg_ok;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: reg_rdata = DATA_W'({canc_q, err_q, done_q, eng_ready, eng_idle, 2'b00});
      A_BAND: reg_rdata = DATA_W'(cfg_bands);
      A_SIGS: reg_rdata = DATA_W'(cfg_sigs);
      A_SPEC: reg_rdata = DATA_W'(cfg_spec_base);
      A_LIB:  reg_rdata = DATA_W'(cfg_lib_base);
      A_BID:  reg_rdata = DATA_W'(best_id_q);
      A_BERR: reg_rdata = DATA_W'(best_err_q);
      A_WID:  reg_rdata = DATA_W'(worst_id_q);
      A_WERR: reg_rdata = DATA_W'(worst_err_q);
      default: reg_rdata = '0;
    endcase
  end

  assert_launch_clears_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> (!done_q && !err_q && !canc_q));

  assert_launch_needs_counts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> (cfg_bands != '0 && cfg_sigs != '0));

  assert_abort_marks_cancel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    eng_abort |-> canc_q);

  assert_done_error_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_q, err_q}));

  assert_results_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(eng_done) && !$past(clear)) |-> ($stable(best_err_q) && $stable(worst_err_q)
      && $stable(best_id_q) && $stable(worst_id_q)));

  assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!eng_start && !eng_abort && !done_q && !err_q && !canc_q
               && cfg_bands == '0 && cfg_sigs == '0));

endmodule

// File: tb/test_spx_ctrl_regs.sv
module test_spx_ctrl_regs;
  logic clk = 1'b0, rst_n = 1'b0, clear = 1'b0;
  logic reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic idle_i = 1'b1, ready_i = 1'b0, done_i = 1'b0, err_i = 1'b0;
  logic [5:0] bid_i = '0, wid_i = '0;
  logic [31:0] berr_i = '0, werr_i = '0;
  logic eng_start, eng_abort;
  logic [6:0] cfg_bands;
  logic [5:0] cfg_sigs;
  logic [31:0] cfg_spec_base, cfg_lib_base;

  int checks = 0, fails = 0;
  bit finished = 0;

  spx_ctrl_regs i_spx_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_idle(idle_i), .eng_ready(ready_i), .eng_done(done_i), .eng_error(err_i),
    .res_best_id(bid_i), .res_best_err(berr_i), .res_worst_id(wid_i), .res_worst_err(werr_i),
    .eng_start(eng_start), .eng_abort(eng_abort),
    .cfg_bands(cfg_bands), .cfg_sigs(cfg_sigs),
    .cfg_spec_base(cfg_spec_base), .cfg_lib_base(cfg_lib_base));

  always #10 clk = ~clk;

  // behavioural reference model
  int m_bands = 0, m_sigs = 0;
  logic [31:0] m_spec = 0, m_lib = 0, m_berr = 0, m_werr = 0;
  int m_bid = 0, m_wid = 0;
  bit m_start = 0, m_abort = 0, m_done = 0, m_err = 0, m_canc = 0;

  always @(posedge clk) begin
    if (!rst_n || clear) begin
      m_bands = 0; m_sigs = 0; m_spec = 0; m_lib = 0;
      m_berr = 0; m_werr = 0; m_bid = 0; m_wid = 0;
      m_start = 0; m_abort = 0; m_done = 0; m_err = 0; m_canc = 0;
    end else begin
      bit ok;
      ok = (m_bands != 0) && (m_sigs != 0);
      m_start = 0; m_abort = 0;
      if (done_i) begin
        m_done = !err_i; m_err = err_i;
        if (!err_i) begin m_bid = bid_i; m_berr = berr_i; m_wid = wid_i; m_werr = werr_i; end
      end
      if (reg_wr) begin
        if (reg_addr == 1) m_bands = reg_wdata & 32'h7f;
        if (reg_addr == 2) m_sigs = reg_wdata & 32'h3f;
        if (reg_addr == 3) m_spec = reg_wdata;
        if (reg_addr == 4) m_lib = reg_wdata;
        if (reg_addr == 0 && reg_wdata[1] && !idle_i && !done_i) begin m_abort = 1; m_canc = 1; end
        if (reg_addr == 0 && reg_wdata[0] && idle_i) begin
          m_done = 0; m_canc = 0; m_err = !ok; m_start = ok;
        end
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    chk(32'(eng_start), 32'(m_start), "R3 start pulse");
    chk(32'(eng_abort), 32'(m_abort), "R6 abort pulse");
    chk(32'(cfg_bands), 32'(m_bands), "R1 bands out");
    chk(32'(cfg_sigs), 32'(m_sigs), "R1 sigs out");
    chk(cfg_spec_base, m_spec, "R1 spec base out");
    chk(cfg_lib_base, m_lib, "R1 lib base out");
  end

  function automatic logic [31:0] status_exp();
    return {25'b0, m_canc, m_err, m_done, ready_i, idle_i, 2'b00};
  endfunction

  task automatic step();
    @(posedge clk); #2;
    reg_wr = 0; done_i = 0; err_i = 0; clear = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    step();
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string req);
    reg_addr = a; #1;
    chk(reg_rdata, exp, req);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #45; rst_n = 1;
    @(posedge clk); #2;
    // reset state
    for (int a = 0; a < 16; a++)
      rd(a[3:0], (a == 0) ? status_exp() : 32'h0, "R10 reset value");
    // R1 config with masking
    wr(1, 32'hffff_ffff); rd(1, 32'h7f, "R1 band mask");
    wr(2, 32'hffff_ffc5); rd(2, 32'h05, "R1 sig mask");
    wr(3, 32'h1000_0040); rd(3, 32'h1000_0040, "R1 spec base");
    wr(4, 32'h2000_0100); rd(4, 32'h2000_0100, "R1 lib base");
    wr(1, 32'd9); rd(1, 32'd9, "R1 band readback");
    // R2 unmapped
    wr(12, 32'hdead_beef);
    for (int a = 9; a < 16; a++) rd(a[3:0], 32'h0, "R2 unmapped offset");
    // R11 live idle/ready
    ready_i = 1; rd(0, 32'h0000_000c, "R11 idle ready bits");
    ready_i = 0; rd(0, 32'h0000_0004, "R11 idle only");
    // R3 accepted start
    wr(0, 32'h1);
    chk(32'(eng_start), 32'h1, "R3 start visible");
    idle_i = 0;
    step();
    chk(32'(eng_start), 32'h0, "R3 single pulse");
    // R3 ignored start while busy
    wr(0, 32'h1);
    chk(32'(eng_start), 32'h0, "R3 busy start ignored");
    // R8/R7 successful completion
    bid_i = 6'd17; berr_i = 32'h0000_0a11; wid_i = 6'd3; werr_i = 32'h00ff_0001;
    done_i = 1; idle_i = 1; step();
    rd(0, status_exp(), "R7 done flag");
    chk(32'(m_done), 32'h1, "R7 model done");
    rd(5, 32'd17, "R8 best id"); rd(6, 32'h0a11, "R8 best err");
    rd(7, 32'd3, "R8 worst id"); rd(8, 32'h00ff_0001, "R8 worst err");
    // R7 error completion, results hold
    wr(0, 32'h1); idle_i = 0;
    rd(0, status_exp(), "R4 flags cleared");
    bid_i = 6'd40; berr_i = 32'h5; done_i = 1; err_i = 1; idle_i = 1; step();
    rd(0, 32'h0000_0024, "R7 error flag");
    rd(5, 32'd17, "R8 best id held"); rd(6, 32'h0a11, "R8 best err held");
    // R5 zero count start
    wr(2, 32'h0);
    wr(0, 32'h1);
    chk(32'(eng_start), 32'h0, "R5 no launch");
    rd(0, 32'h0000_0024, "R5 error set");
    wr(2, 32'd4);
    // R6 stop while idle ignored
    wr(0, 32'h2);
    chk(32'(eng_abort), 32'h0, "R6 idle stop ignored");
    rd(0, 32'h0000_0024, "R6 idle stop no flag");
    // R6 abort while busy
    wr(0, 32'h1); idle_i = 0;
    wr(0, 32'h2);
    chk(32'(eng_abort), 32'h1, "R6 abort pulse");
    idle_i = 1;
    rd(0, 32'h0000_0044, "R6 cancelled flag");
    step();
    chk(32'(eng_abort), 32'h0, "R6 abort single");
    // R9 stop with completion in same cycle
    wr(0, 32'h1); idle_i = 0;
    rd(0, 32'h0000_0000, "R4 cancelled cleared");
    bid_i = 6'd22; berr_i = 32'h77; wid_i = 6'd1; werr_i = 32'h99;
    reg_wr = 1; reg_addr = 0; reg_wdata = 32'h2; done_i = 1;
    step();
    idle_i = 1;
    chk(32'(eng_abort), 32'h0, "R9 no abort on completion");
    rd(0, 32'h0000_0014, "R9 done not cancelled");
    rd(5, 32'd22, "R9 results captured");
    // R10 clear with concurrent launch
    reg_wr = 1; reg_addr = 0; reg_wdata = 32'h1; clear = 1;
    step();
    chk(32'(eng_start), 32'h0, "R10 clear beats start");
    for (int a = 1; a < 9; a++) rd(a[3:0], 32'h0, "R10 cleared");
    rd(0, 32'h0000_0004, "R10 status cleared");
    // R10 async reset
    wr(1, 32'd3);
    #3 rst_n = 0; #1;
    chk(32'(cfg_bands), 32'h0, "R10 async reset");
    @(posedge clk); #2 rst_n = 1;
    step();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule